// File: doc/BRIEF.md
# Credit-Driven Event Dispatcher

This block decides which builder unit assembles each triggered event. Triggers arrive with a trigger number and wait in a small queue. Builder units announce spare capacity as credits. Each unit's credits are kept in its own saturating counter. When the oldest queued trigger can go to some unit that holds a credit, the dispatcher picks that unit and spends one of its credits. In the same cycle it issues two things: a build command to the chosen unit, and a fragment request to the readout buffers. Both carry the destination index and the trigger number.

Destinations are not assigned from a fixed table. They follow the credit returns, so a unit that finishes work slowly returns fewer credits and receives fewer events, and it does not hold back the rest. When no unit holds any credit, dispatch stops. The queue then fills, and the trigger input is back-pressured through its ready signal.

Units that hold credits are served in rotation. The search starts at the unit after the last one served. All fragments of an event go to a single destination, because exactly one command is issued per trigger number.

Top module: `evt_dispatch`

## Requirements
- R1: After reset, `cmd_valid` and `req_valid` are 0, `trig_ready` is 1, and every unit holds zero credits.
- R2: Trigger numbers leave on `cmd_trig` in exactly the order in which they were accepted (a trigger is accepted on a rising edge where `trig_valid` and `trig_ready` are both 1).
- R3: No unit is named on `cmd_unit` more times than the credits it has announced.
- R4: The queue holds 16 trigger numbers. `trig_ready` is 0 exactly when 16 are waiting. A trigger offered while `trig_ready` is 0 is dropped. No command is issued while no unit holds a credit.
- R5: When several units hold credits, the destination is the first unit with a credit, searching in ascending index order with wrap-around. The search starts at the index one above the last destination served, and unit 0 is searched first after reset.
- R6: Every command appears on the builder-side outputs (`cmd_*`) and the readout-side outputs (`req_*`) in the same cycle, with identical unit index and trigger number.
- R7: If a trigger is accepted at edge k while the queue is empty and some unit holds a credit, its command is valid after edge k+1 and not after edge k.
- R8: A credit counter saturates at 15. An announce that would take it above 15 leaves it at 15. An announce and a dispatch to the same unit at the same edge both take effect.
- R9: An announce whose count is 0 changes no credit.
- R10: At most one command is issued per cycle. A command is issued whenever the queue is non-empty and at least one unit held a credit at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_valid | input | 1 | A trigger number is offered |
| trig_num | input | 16 | Trigger number of the offered event |
| trig_ready | output | 1 | Queue can take a trigger number |
| ann_valid | input | 1 | A builder unit returns credits |
| ann_unit | input | 3 | Index of the announcing unit |
| ann_count | input | 4 | Number of credits returned |
| cmd_valid | output | 1 | Build command valid |
| cmd_unit | output | 3 | Builder unit that must build the event |
| cmd_trig | output | 16 | Trigger number to build |
| req_valid | output | 1 | Fragment request valid |
| req_unit | output | 3 | Destination the readout buffers must send to |
| req_trig | output | 16 | Trigger number whose fragments are requested |

## Verification
The hardest state to reach is a credit counter that is already at its ceiling and receives a further announce, in some cases at the same edge as a dispatch to that unit. The stimulus reaches it by first announcing credits to one unit while the queue is empty, then releasing a burst of triggers. The stimulus also fills the queue with no credits present, so that the full-queue refusal and the stall can be seen. After that, a long random phase runs with sparse, uneven announces, and a cycle-level model of the requirements predicts every destination and trigger number.

// File: rtl/evt_dispatch_pkg.sv
package evt_dispatch_pkg;
  localparam int DEF_UNITS  = 8;
  localparam int DEF_CRED_W = 4;
  localparam int DEF_TRIG_W = 16;
  localparam int DEF_QDEPTH = 16;
endpackage

// File: rtl/trig_queue.sv
module trig_queue #(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;

  // storage without reset so it maps onto distributed or block memory
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= (int'(wr_ptr) == DEPTH-1) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (int'(rd_ptr) == DEPTH-1) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign count = cnt_q;
endmodule

// File: rtl/credit_bank.sv
module credit_bank #(
  parameter int N  = 8,
  parameter int CW = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ann_valid,
  input  logic [$clog2(N)-1:0]   ann_unit,
  input  logic [CW-1:0]          ann_count,
  input  logic                   take_valid,
  input  logic [$clog2(N)-1:0]   take_unit,
  output logic [N-1:0]           has_credit,
  output logic [N*CW-1:0]        cred_flat
);
  localparam int UW   = $clog2(N);
  localparam int CMAX = (1 << CW) - 1;

  for (genvar u = 0; u < N; u++) begin : g_unit
    logic [CW-1:0] cnt_q;
    logic [CW:0]   sum;
    logic          add_hit, take_hit;

    assign add_hit  = ann_valid  && (ann_unit  == UW'(u));
    assign take_hit = take_valid && (take_unit == UW'(u));

    always_comb begin
      sum = {1'b0, cnt_q};
      if (take_hit) sum = sum - 1'b1;
      if (add_hit)  sum = sum + {1'b0, ann_count};
    end

    always_ff @(posedge clk) begin
      if (rst)                         cnt_q <= '0;
      else if (int'(sum) > CMAX)       cnt_q <= CW'(CMAX);
      else                             cnt_q <= sum[CW-1:0];
    end

    assign has_credit[u]             = (cnt_q != '0);
    assign cred_flat[u*CW +: CW]     = cnt_q;
  end
endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         req,
  input  logic                 advance,
  output logic [N-1:0]         gnt,
  output logic [$clog2(N)-1:0] gnt_idx,
  output logic                 any
);
  localparam int UW = $clog2(N);

  logic [UW-1:0] last_q;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int i = 0; i < N; i++) begin
      int k;
      k = (int'(last_q) + 1 + i) % N;
      if (!any && req[k]) begin
        any     = 1'b1;
        gnt[k]  = 1'b1;
        gnt_idx = UW'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  last_q <= UW'(N-1);
    else if (advance && any)  last_q <= gnt_idx;
  end
endmodule

// File: rtl/evt_dispatch.sv
module evt_dispatch
  import evt_dispatch_pkg::*;
#(
  parameter int NUM_UNITS = DEF_UNITS,
  parameter int CRED_W    = DEF_CRED_W,
  parameter int TRIG_W    = DEF_TRIG_W,
  parameter int QDEPTH    = DEF_QDEPTH
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         trig_valid,
  input  logic [TRIG_W-1:0]            trig_num,
  output logic                         trig_ready,
  input  logic                         ann_valid,
  input  logic [$clog2(NUM_UNITS)-1:0] ann_unit,
  input  logic [CRED_W-1:0]            ann_count,
  output logic                         cmd_valid,
  output logic [$clog2(NUM_UNITS)-1:0] cmd_unit,
  output logic [TRIG_W-1:0]            cmd_trig,
  output logic                         req_valid,
  output logic [$clog2(NUM_UNITS)-1:0] req_unit,
  output logic [TRIG_W-1:0]            req_trig
);
  localparam int UW  = $clog2(NUM_UNITS);
  localparam int QCW = $clog2(QDEPTH+1);

  logic [TRIG_W-1:0]        q_head;
  logic [QCW-1:0]           q_count;
  logic                     q_full, q_empty, push, pop;
  logic [NUM_UNITS-1:0]     has_credit, gnt;
  logic [NUM_UNITS*CRED_W-1:0] cred_flat;
  logic [UW-1:0]            gnt_idx;
  logic                     any_credit;

  assign q_full     = (int'(q_count) == QDEPTH);
  assign q_empty    = (q_count == '0);
  assign trig_ready = !q_full;
  assign push       = trig_valid && !q_full;
  assign pop        = !q_empty && any_credit;

  trig_queue #(.W(TRIG_W), .DEPTH(QDEPTH)) u_queue (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_data (trig_num),
    .pop       (pop),
    .head      (q_head),
    .count     (q_count)
  );

  credit_bank #(.N(NUM_UNITS), .CW(CRED_W)) u_credits (
    .clk        (clk),
    .rst        (rst),
    .ann_valid  (ann_valid),
    .ann_unit   (ann_unit),
    .ann_count  (ann_count),
    .take_valid (pop),
    .take_unit  (gnt_idx),
    .has_credit (has_credit),
    .cred_flat  (cred_flat)
  );

  rr_arbiter #(.N(NUM_UNITS)) u_rr (
    .clk     (clk),
    .rst     (rst),
    .req     (has_credit),
    .advance (pop),
    .gnt     (gnt),
    .gnt_idx (gnt_idx),
    .any     (any_credit)
  );

  // builder-side command register
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_unit  <= '0;
      cmd_trig  <= '0;
    end else begin
      cmd_valid <= pop;
      if (pop) begin
        cmd_unit <= gnt_idx;
        cmd_trig <= q_head;
      end
    end
  end

  // readout-side request register
  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_unit  <= '0;
      req_trig  <= '0;
    end else begin
      req_valid <= pop;
      if (pop) begin
        req_unit <= gnt_idx;
        req_trig <= q_head;
      end
    end
  end
endmodule

// File: rtl/evt_dispatch_chk.sv
module evt_dispatch_chk #(
  parameter int N      = 8,
  parameter int CW     = 4,
  parameter int TW     = 16,
  parameter int QDEPTH = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       trig_ready,
  input logic                       cmd_valid,
  input logic [$clog2(N)-1:0]       cmd_unit,
  input logic [TW-1:0]              cmd_trig,
  input logic                       req_valid,
  input logic [$clog2(N)-1:0]       req_unit,
  input logic [TW-1:0]              req_trig,
  input logic [$clog2(QDEPTH+1)-1:0] q_count,
  input logic [N*CW-1:0]            cred_flat,
  input logic [N-1:0]               gnt
);
  logic [N-1:0] nz, prev_nz;
  logic         prev_nonempty;

  always_comb
    for (int u = 0; u < N; u++) nz[u] = (cred_flat[u*CW +: CW] != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_nz       <= '0;
      prev_nonempty <= 1'b0;
    end else begin
      prev_nz       <= nz;
      prev_nonempty <= (q_count != '0);
    end
  end

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cmd_valid && !req_valid));

  p_twin_outputs_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (req_valid && cmd_unit == req_unit && cmd_trig == req_trig));

  p_twin_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |-> !req_valid);

  p_full_blocks_r4: assert property (@(posedge clk) disable iff (rst)
    (int'(q_count) == QDEPTH) |-> !trig_ready);

  p_credit_held_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> prev_nz[cmd_unit]);

  p_queue_had_entry_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> prev_nonempty);

  p_single_grant_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));
endmodule

bind evt_dispatch evt_dispatch_chk #(
  .N(NUM_UNITS), .CW(CRED_W), .TW(TRIG_W), .QDEPTH(QDEPTH)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .trig_ready (trig_ready),
  .cmd_valid  (cmd_valid),
  .cmd_unit   (cmd_unit),
  .cmd_trig   (cmd_trig),
  .req_valid  (req_valid),
  .req_unit   (req_unit),
  .req_trig   (req_trig),
  .q_count    (q_count),
  .cred_flat  (cred_flat),
  .gnt        (gnt)
);

// File: tb/evt_dispatch_tb.sv
module evt_dispatch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig_valid = 1'b0;
  logic [15:0] trig_num = '0;
  logic        trig_ready;
  logic        ann_valid = 1'b0;
  logic [2:0]  ann_unit = '0;
  logic [3:0]  ann_count = '0;
  logic        cmd_valid, req_valid;
  logic [2:0]  cmd_unit, req_unit;
  logic [15:0] cmd_trig, req_trig;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_dispatch u_dut (
    .clk(clk), .rst(rst),
    .trig_valid(trig_valid), .trig_num(trig_num), .trig_ready(trig_ready),
    .ann_valid(ann_valid), .ann_unit(ann_unit), .ann_count(ann_count),
    .cmd_valid(cmd_valid), .cmd_unit(cmd_unit), .cmd_trig(cmd_trig),
    .req_valid(req_valid), .req_unit(req_unit), .req_trig(req_trig)
  );

  // ---------------- reference model built from the requirements
  int          mcred [N];
  logic [15:0] mq [$];
  int          mlast;
  bit          expv;
  int          expu;
  logic [15:0] expt;
  int          per_unit [N];

  function automatic int sat15(int v);
    return (v > 15) ? 15 : v;
  endfunction

  function automatic int rr_pick(int last);
    for (int i = 0; i < N; i++) begin
      int k;
      k = (last + 1 + i) % N;
      if (mcred[k] > 0) return k;
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int u = 0; u < N; u++) mcred[u] = 0;
      mq.delete();
      mlast = N - 1;
      expv  = 0;
    end else begin
      int  pick;
      bit  can_push;
      can_push = (mq.size() < 16);
      pick = rr_pick(mlast);
      expv = (mq.size() > 0) && (pick >= 0);
      if (expv) begin
        expu = pick;
        expt = mq.pop_front();
        mcred[pick] = mcred[pick] - 1;
        mlast = pick;
      end
      if (trig_valid && can_push) mq.push_back(trig_num);
      if (ann_valid) mcred[ann_unit] = sat15(mcred[ann_unit] + int'(ann_count));
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(cmd_valid == expv, "R10 cmd_valid", int'(cmd_valid), int'(expv));
      check(trig_ready == (mq.size() < 16), "R4 trig_ready", int'(trig_ready),
            int'(mq.size() < 16));
      if (cmd_valid && expv) begin
        check(int'(cmd_unit) == expu, "R5 destination", int'(cmd_unit), expu);
        check(cmd_trig == expt, "R2 trigger order", int'(cmd_trig), int'(expt));
        per_unit[cmd_unit]++;
      end
      check(req_valid == cmd_valid && req_unit == cmd_unit && req_trig == cmd_trig,
            "R6 twin outputs", int'(req_trig), int'(cmd_trig));
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic announce(int u, int c);
    ann_valid = 1'b1; ann_unit = 3'(u); ann_count = 4'(c);
    tick();
    ann_valid = 1'b0;
  endtask

  task automatic offer(logic [15:0] v);
    trig_valid = 1'b1; trig_num = v;
    tick();
    trig_valid = 1'b0;
  endtask

  // watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0017));
    for (int u = 0; u < N; u++) per_unit[u] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: idle reset state
    check(cmd_valid == 0 && req_valid == 0, "R1 outputs idle", int'(cmd_valid), 0);
    check(trig_ready == 1, "R1 ready after reset", int'(trig_ready), 1);

    // R9: zero-count announce to unit 5, R8: unit 3 driven past its ceiling
    announce(5, 0);
    announce(3, 15);
    announce(3, 15);
    announce(3, 5);
    for (int i = 0; i < 20; i++) offer(16'(16'h1000 + i));
    repeat (30) tick();
    check(per_unit[3] == 15, "R8 saturated credits used", per_unit[3], 15);
    check(per_unit[5] == 0, "R9 zero announce ignored", per_unit[5], 0);
    check(per_unit[0] == 0, "R3 no credit no dispatch", per_unit[0], 0);

    // R4: fill the queue with no credits, keep offering
    for (int i = 0; i < 14; i++) offer(16'(16'h2000 + i));
    check(trig_ready == 0, "R4 full queue refuses", int'(trig_ready), 0);
    repeat (5) tick();
    check(cmd_valid == 0, "R4 stall without credit", int'(cmd_valid), 0);

    // drain with two units
    announce(6, 15);
    announce(1, 15);
    repeat (30) tick();

    // R7: latency with empty queue and credits present
    trig_valid = 1'b1; trig_num = 16'hBEEF;
    tick();
    trig_valid = 1'b0;
    check(cmd_valid == 0, "R7 not after first edge", int'(cmd_valid), 0);
    tick();
    check(cmd_valid == 1 && cmd_trig == 16'hBEEF, "R7 valid after second edge",
          int'(cmd_trig), 16'hBEEF);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      trig_valid = ($urandom_range(0, 99) < 45);
      trig_num   = 16'($urandom);
      ann_valid  = ($urandom_range(0, 99) < 20);
      ann_unit   = 3'($urandom_range(0, 7));
      ann_count  = 4'($urandom_range(0, (c % 500 < 250) ? 3 : 15));
      tick();
    end
    trig_valid = 1'b0; ann_valid = 1'b0;
    repeat (10) tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule